// File: doc/BRIEF.md
# Barrel Shift Unit with Condition Flags

This block is the shifter of a small processor datapath. It is purely combinational: in the same cycle it takes a 32-bit operand, a shift kind, a shift count and the current carry flag. It returns the shifted word together with negative, zero and carry flags. It supports logical left, logical right, arithmetic right and rotate right.

The count comes from one of two sources, chosen by `reg_mode_i`:

- **Immediate mode** uses a 5-bit field from the instruction word. Its meaning depends on the shift kind.
- **Register mode** uses the low byte of a register value, so counts from 0 to 255 can occur.

The unit decodes the count itself. It produces the correct carry for every count, including zero and counts of 32 and above.

Shift kind encoding on `kind_i`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.

Top module: `barrel_shift_unit`

## Requirements
- R1: Immediate logical left (kind 0, reg_mode_i=0) with a count n from 1 to 31 returns operand << n, and the carry is operand bit 32-n.
- R2: In immediate mode with kind 1 or 2, field value 0 means a count of 32, and values 1 to 31 are used as they stand.
- R3: In register mode only bits 7:0 of reg_amt_i form the count, and bits 31:8 have no effect on any output.
- R4: In immediate mode, kind 3 performs no rotation: the result equals the operand and the carry equals carry_i.
- R5: A count of zero returns the operand unchanged with carry_o equal to carry_i, for every kind. This covers immediate left with field 0 and register mode with a low byte of 0.
- R6: Logical left by exactly 32 gives a zero result with carry equal to operand bit 0. By more than 32 it gives a zero result and a zero carry.
- R7: Logical right by n from 1 to 31 gives operand >> n with carry equal to operand bit n-1. By 32 it gives zero with carry equal to operand bit 31. By more than 32 both result and carry are zero.
- R8: Arithmetic right by n from 1 to 31 fills with the sign bit, and the carry is operand bit n-1. By 32 or more, every result bit and the carry equal operand bit 31.
- R9: Register-mode rotate right by a nonzero count rotates by the count modulo 32, and the carry equals result bit 31. A nonzero multiple of 32 returns the operand with carry equal to operand bit 31.
- R10: neg_o always equals result bit 31, and zero_o is 1 exactly when the 32-bit result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| reg_mode_i | input | 1 | 1 selects the register count, 0 selects the immediate field |
| imm_amt_i | input | 5 | Immediate count field |
| reg_amt_i | input | 32 | Register value; its low byte is the count |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted word |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
The embedded checks are immediate assertions evaluated as the combinational logic settles. They assume that all inputs hold known 0/1 values whenever the logic is evaluated. The stimulus therefore gives every input a defined value from time zero. It changes inputs only between the sample points of a check and never drives X or Z. The kind field is always one of the four defined codes, and counts are chosen to cover 0, the 31/32/33 boundary, large register counts and counts whose upper register bits are set.

// File: rtl/shift_pkg.sv
package shift_pkg;

    parameter int DATA_W  = 32;
    parameter int IMM_W   = $clog2(DATA_W);
    parameter int CNT_W   = 8;
    parameter int ROT_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        shift_kind_e       kind;
        logic [CNT_W-1:0]  count;
        logic              cin;
    } shift_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              carry;
    } shift_rsp_t;

    typedef struct packed {
        logic neg;
        logic zero;
    } nz_flags_t;

    // Immediate count: right shifts treat a zero field as a full-width shift.
    function automatic logic [CNT_W-1:0] imm_count(input shift_kind_e k,
                                                   input logic [IMM_W-1:0] f);
        logic [CNT_W-1:0] c;
        case (k)
            SH_LSL:         c = CNT_W'(f);
            SH_LSR, SH_ASR: c = (f == '0) ? CNT_W'(DATA_W) : CNT_W'(f);
            default:        c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode
    import shift_pkg::*;
(
    input  shift_kind_e        kind_i,
    input  logic               reg_mode_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [DATA_W-1:0]  reg_i,
    output logic [CNT_W-1:0]   count_o
);

    always_comb begin
        if (reg_mode_i) begin
            count_o = reg_i[CNT_W-1:0];
        end else begin
            count_o = imm_count(kind_i, imm_i);
        end

        // R2
        imm_right_full_chk: assert (reg_mode_i || imm_i != '0 ||
                                    !(kind_i == SH_LSR || kind_i == SH_ASR) ||
                                    count_o == CNT_W'(DATA_W));
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
(
    input  shift_req_t req_i,
    output shift_rsp_t rsp_o
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]    left_ext;
    logic [EXT_W-1:0]    lright_ext;
    logic [EXT_W-1:0]    aright_ext;
    logic [2*DATA_W-1:0] wrap;
    logic [CNT_W-1:0]    asr_cnt;
    logic                sign;

    always_comb begin
        sign       = req_i.operand[DATA_W-1];
        asr_cnt    = (req_i.count > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : req_i.count;
        // guard bit above the word catches the last bit out on the left
        left_ext   = {1'b0, req_i.operand} << req_i.count;
        // guard bit below the word catches the last bit out on the right
        lright_ext = {req_i.operand, 1'b0} >> req_i.count;
        aright_ext = EXT_W'($signed({req_i.operand, 1'b0}) >>> asr_cnt);
        wrap       = {req_i.operand, req_i.operand} >> req_i.count[ROT_W-1:0];

        if (req_i.count == '0) begin
            rsp_o.result = req_i.operand;
            rsp_o.carry  = req_i.cin;
        end else begin
            case (req_i.kind)
                SH_LSL: begin
                    rsp_o.result = left_ext[DATA_W-1:0];
                    rsp_o.carry  = left_ext[DATA_W];
                end
                SH_LSR: begin
                    rsp_o.result = lright_ext[EXT_W-1:1];
                    rsp_o.carry  = lright_ext[0];
                end
                SH_ASR: begin
                    rsp_o.result = aright_ext[EXT_W-1:1];
                    rsp_o.carry  = aright_ext[0];
                end
                default: begin
                    rsp_o.result = wrap[DATA_W-1:0];
                    rsp_o.carry  = wrap[DATA_W-1];
                end
            endcase
        end

        // R5
        zero_count_pass_chk: assert (req_i.count != '0 ||
                                     (rsp_o.carry == req_i.cin &&
                                      rsp_o.result == req_i.operand));
        // R6
        lsl_beyond_clear_chk: assert (req_i.kind != SH_LSL ||
                                      req_i.count <= CNT_W'(DATA_W) ||
                                      (rsp_o.result == '0 && !rsp_o.carry));
        // R8
        asr_saturate_chk: assert (req_i.kind != SH_ASR ||
                                  req_i.count < CNT_W'(DATA_W) ||
                                  (rsp_o.result == {DATA_W{sign}} && rsp_o.carry == sign));
        // R9
        ror_carry_msb_chk: assert (req_i.kind != SH_ROR || req_i.count == '0 ||
                                   rsp_o.carry == rsp_o.result[DATA_W-1]);
    end

endmodule

// File: rtl/shift_flags.sv
module shift_flags
    import shift_pkg::*;
(
    input  logic [DATA_W-1:0] result_i,
    output nz_flags_t         flags_o
);

    always_comb begin
        flags_o.neg  = result_i[DATA_W-1];
        flags_o.zero = (result_i == '0);
    end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import shift_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic              reg_mode_i,
    input  logic [IMM_W-1:0]  imm_amt_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              neg_o,
    output logic              zero_o,
    output logic              carry_o
);

    shift_kind_e     kind;
    logic [CNT_W-1:0] count;
    shift_req_t      req;
    shift_rsp_t      rsp;
    nz_flags_t       flags;

    assign kind = shift_kind_e'(kind_i);

    shift_count_decode u_decode (
        .kind_i     (kind),
        .reg_mode_i (reg_mode_i),
        .imm_i      (imm_amt_i),
        .reg_i      (reg_amt_i),
        .count_o    (count)
    );

    always_comb begin
        req.operand = opnd_i;
        req.kind    = kind;
        req.count   = count;
        req.cin     = carry_i;
    end

    shift_core u_core (
        .req_i (req),
        .rsp_o (rsp)
    );

    shift_flags u_flags (
        .result_i (rsp.result),
        .flags_o  (flags)
    );

    assign result_o = rsp.result;
    assign carry_o  = rsp.carry;
    assign neg_o    = flags.neg;
    assign zero_o   = flags.zero;

endmodule

// File: tb/barrel_shift_unit_test.sv
module barrel_shift_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd = '0;
    logic [1:0]  kind = '0;
    logic        regm = 1'b0;
    logic [4:0]  imm  = '0;
    logic [31:0] ramt = '0;
    logic        cin  = 1'b0;
    logic [31:0] res;
    logic        neg, zero, cout;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    barrel_shift_unit uut (
        .opnd_i(opnd), .kind_i(kind), .reg_mode_i(regm), .imm_amt_i(imm),
        .reg_amt_i(ramt), .carry_i(cin), .result_o(res), .neg_o(neg),
        .zero_o(zero), .carry_o(cout)
    );

    // Reference: one bit per step, count taken from the requirements.
    function automatic logic [32:0] model(logic [31:0] op, logic [1:0] k, logic rm,
                                          logic [4:0] f, logic [31:0] r, logic c);
        int n;
        logic [31:0] v = op;
        logic cy = c;
        if (rm) n = int'(r[7:0]);
        else if (k == 2'd3) n = 0;
        else if (k != 2'd0 && f == 5'd0) n = 32;
        else n = int'(f);
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin cy = v[31]; v = v << 1; end
                2'd1: begin cy = v[0];  v = v >> 1; end
                2'd2: begin cy = v[0];  v = {v[31], v[31:1]}; end
                default: begin cy = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {cy, v};
    endfunction

    task automatic run(string tag, logic [31:0] op, logic [1:0] k, logic rm,
                       logic [4:0] f, logic [31:0] r, logic c);
        logic [32:0] exp;
        @(negedge clk);
        opnd = op; kind = k; regm = rm; imm = f; ramt = r; cin = c;
        #1;
        exp = model(op, k, rm, f, r, c);
        total++;
        if (res !== exp[31:0] || cout !== exp[32] ||
            neg !== exp[31] || zero !== (exp[31:0] == 0)) begin
            bad++;
            $display("FAIL %s: got res=%h c=%b n=%b z=%b exp res=%h c=%b n=%b z=%b",
                     tag, res, cout, neg, zero, exp[31:0], exp[32], exp[31],
                     (exp[31:0] == 0));
        end
    endtask

    task automatic t_idle();
        @(negedge clk); #1;
        total++;
        if (res !== 0 || zero !== 1'b1 || cout !== 1'b0) begin
            bad++;
            $display("FAIL R10 idle: res=%h z=%b c=%b exp res=0 z=1 c=0", res, zero, cout);
        end
    endtask

    task automatic t_lsl_imm();   // R1
        for (int n = 1; n < 32; n += 5) run("R1 lsl imm", 32'hC35A_96E1, 2'd0, 0, 5'(n), 0, 0);
        run("R1 lsl imm 31", 32'h0000_0003, 2'd0, 0, 5'd31, 0, 0);
    endtask

    task automatic t_imm_right_full();   // R2
        run("R2 lsr imm0=32", 32'h8000_0001, 2'd1, 0, 5'd0, 0, 0);
        run("R2 asr imm0=32", 32'h8000_0000, 2'd2, 0, 5'd0, 0, 0);
        run("R2 asr imm0=32 pos", 32'h7FFF_FFFF, 2'd2, 0, 5'd0, 0, 1);
        run("R2 lsr imm 7", 32'hF0F0_1234, 2'd1, 0, 5'd7, 0, 1);
    endtask

    task automatic t_reg_upper_ignored();   // R3
        run("R3 upper bits lsl", 32'h1234_5678, 2'd0, 1, 0, 32'hFFFF_FF04, 0);
        run("R3 upper bits zero cnt", 32'h1234_5678, 2'd1, 1, 0, 32'hABCD_0100, 1);
        run("R3 upper bits ror", 32'h8765_4321, 2'd3, 1, 0, 32'h7700_0008, 0);
    endtask

    task automatic t_imm_rotate();   // R4
        run("R4 imm ror noop", 32'h8000_00F1, 2'd3, 0, 5'd9, 0, 1);
        run("R4 imm ror noop c0", 32'h0000_0001, 2'd3, 0, 5'd0, 0, 0);
    endtask

    task automatic t_zero_count();   // R5
        run("R5 lsl imm0 c1", 32'hDEAD_BEEF, 2'd0, 0, 5'd0, 0, 1);
        run("R5 lsl imm0 c0", 32'hDEAD_BEEF, 2'd0, 0, 5'd0, 0, 0);
        for (int k = 0; k < 4; k++) run("R5 reg zero", 32'h8000_0001, 2'(k), 1, 0, 32'h0000_0000, 1);
    endtask

    task automatic t_lsl_big();   // R6
        run("R6 lsl 32", 32'h0000_0001, 2'd0, 1, 0, 32, 0);
        run("R6 lsl 33", 32'hFFFF_FFFF, 2'd0, 1, 0, 33, 1);
        run("R6 lsl 255", 32'hFFFF_FFFF, 2'd0, 1, 0, 255, 1);
    endtask

    task automatic t_lsr();   // R7
        run("R7 lsr 1", 32'h0000_0003, 2'd1, 1, 0, 1, 0);
        run("R7 lsr 31", 32'h8000_0000, 2'd1, 1, 0, 31, 0);
        run("R7 lsr 32", 32'h8000_0000, 2'd1, 1, 0, 32, 0);
        run("R7 lsr 33", 32'hFFFF_FFFF, 2'd1, 1, 0, 33, 1);
    endtask

    task automatic t_asr();   // R8
        run("R8 asr 4 neg", 32'h8000_0018, 2'd2, 1, 0, 4, 0);
        run("R8 asr 31", 32'h4000_0000, 2'd2, 1, 0, 31, 1);
        run("R8 asr 40 neg", 32'h8000_0000, 2'd2, 1, 0, 40, 0);
        run("R8 asr 200 pos", 32'h7FFF_FFFF, 2'd2, 1, 0, 200, 1);
    endtask

    task automatic t_ror();   // R9
        run("R9 ror 4", 32'h1234_5678, 2'd3, 1, 0, 4, 0);
        run("R9 ror 31", 32'h0000_0001, 2'd3, 1, 0, 31, 1);
        run("R9 ror 32", 32'h8000_0001, 2'd3, 1, 0, 32, 0);
        run("R9 ror 64", 32'h7000_0001, 2'd3, 1, 0, 64, 1);
        run("R9 ror 37", 32'h0000_0010, 2'd3, 1, 0, 37, 1);
    endtask

    task automatic t_flags();   // R10
        run("R10 negative", 32'h4000_0000, 2'd0, 0, 5'd1, 0, 0);
        run("R10 zero", 32'h0000_0100, 2'd1, 0, 5'd9, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_lsl_imm();
        t_imm_right_full();
        t_reg_upper_ignored();
        t_imm_rotate();
        t_zero_count();
        t_lsl_big();
        t_lsr();
        t_asr();
        t_ror();
        t_flags();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, got done=0 exp done=1");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule